// File: doc/BRIEF.md
# Buck Converter Start-Up and Protection Sequencer

This block supervises the control loop of a synchronous step-down converter. It reads single-bit comparator results for power-on-ready, enable, feedback under-voltage, feedback above the power-good level, over-current and compensation-pin shutdown. It also reads a one-cycle tick from the switching oscillator. From these it produces three outputs: an 11-bit soft-start reference code that feeds the reference DAC, a drivers-enable signal for the high-side and low-side gate drivers, and a release signal for the open-drain power-good pin.

On a valid start, the reference code rises by one step on each switching tick. After 2048 ticks the converter regulates at full scale. If feedback falls too low during regulation, the block stops switching, waits 2048 ticks and then ramps again from zero. An over-current trip stops switching permanently. Only removing power-on-ready or enable clears that latch. A low compensation pin stops switching for as long as it is held low.

Top module: `buck_seq`

## Requirements
- R1: After a synchronous reset, `drv_en` is 0, `ss_code` is 0 and `pg_release` is 0.
- R2: A start needs `por_ok` and `en_hi` high together. With only one of them high, `drv_en` and `ss_code` stay 0 whatever `cyc_tick` does.
- R3: One clock after a start, `drv_en` is 1 and `ss_code` is 0. `ss_code` then counts the ticks taken and holds between ticks. After 2047 ticks it reads 2047 (all ones) and the block is still ramping (`pg_release` 0). The 2048th tick enters regulation, where `ss_code` stays at 2047.
- R4: If `por_ok` or `en_hi` falls, then from the next clock `ss_code` is 0, `drv_en` is 0 and `pg_release` is 0.
- R5: If `fb_uv` is high at a clock edge during regulation, the block enters hiccup: `drv_en` 0, `ss_code` 0, `pg_release` 0. Drivers stay off through 2047 ticks. The 2048th tick restarts the soft-start ramp from 0 with `drv_en` 1.
- R6: `fb_uv` is ignored while the soft-start ramp is running.
- R7: If `ocp_trip` is high at a clock edge during the ramp or regulation, the block latches off with `drv_en` 0, `ss_code` 0 and `pg_release` 0. It stays there for any other input until `por_ok` or `en_hi` falls. The next start then begins a fresh ramp from 0.
- R8: `pg_release` is 1 only during regulation with `fb_pg_hi` high and `comp_sd` low. It follows `fb_pg_hi` in the same cycle. The 90 %/85 % hysteresis lives in the comparator that drives `fb_pg_hi`.
- R9: While `comp_sd` is high, `drv_en` and `pg_release` are 0 in the same cycle and the ramp count ignores ticks. The ramp resumes from the held value once `comp_sd` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_ok | input | 1 | Supply power-on-ready |
| en_hi | input | 1 | Enable comparator output (hysteresis included) |
| fb_uv | input | 1 | Feedback below the under-voltage level |
| fb_pg_hi | input | 1 | Feedback above the power-good level (hysteresis included) |
| ocp_trip | input | 1 | Over-current comparator tripped |
| comp_sd | input | 1 | Compensation pin pulled below the shutdown level |
| cyc_tick | input | 1 | One-clock pulse per switching cycle |
| ss_code | output | 11 | Soft-start reference code |
| drv_en | output | 1 | Gate drivers allowed to switch |
| pg_release | output | 1 | 1 releases the open-drain power-good pin, 0 pulls it low |

## Verification
A wrong state shows up at the ports on the first clock after the faulty edge. An unexpected exit from latch-out or hiccup turns `drv_en` back on at once. A ramp that reaches regulation early or late is caught by power-good: it stays low at tick 2047 and must rise exactly at tick 2048. A counter that slips under shutdown or under a masked under-voltage condition reads as a wrong `ss_code` value after a known number of ticks. The hiccup wait is checked by looking for a `drv_en` change exactly between tick 2047 and tick 2048.

// File: rtl/buck_seq_pkg.sv
`timescale 1ns/1ps
package buck_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_SOFT   = 3'd1,
        ST_RUN    = 3'd2,
        ST_HICCUP = 3'd3,
        ST_LATCH  = 3'd4
    } seq_state_e;

    function automatic logic holds_count_clear(input seq_state_e s);
        return (s == ST_OFF) || (s == ST_RUN) || (s == ST_LATCH);
    endfunction

endpackage

// File: rtl/bseq_count.sv
`timescale 1ns/1ps
module bseq_count #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         last
);
    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc)   cnt <= cnt + 1'b1;
    end

    assign last = &cnt;
endmodule

// File: rtl/bseq_ctrl.sv
`timescale 1ns/1ps
module bseq_ctrl
    import buck_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic       fb_uv,
    input  logic       ocp_trip,
    input  logic       comp_sd,
    input  logic       tick,
    input  logic       cnt_last,
    output seq_state_e st,
    output logic       cnt_clr,
    output logic       cnt_inc
);
    seq_state_e nxt;
    logic       ramp_step;

    assign ramp_step = tick && !comp_sd;

    always_comb begin
        nxt = st;
        if (!go) begin
            nxt = ST_OFF;
        end else begin
            case (st)
                ST_OFF:    nxt = ST_SOFT;
                ST_SOFT:   if (ocp_trip) nxt = ST_LATCH;
                           else if (ramp_step && cnt_last) nxt = ST_RUN;
                ST_RUN:    if (ocp_trip) nxt = ST_LATCH;
                           else if (fb_uv) nxt = ST_HICCUP;
                ST_HICCUP: if (tick && cnt_last) nxt = ST_SOFT;
                ST_LATCH:  nxt = ST_LATCH;
                default:   nxt = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_OFF;
        else     st <= nxt;
    end

    assign cnt_inc = (st == ST_SOFT && ramp_step) || (st == ST_HICCUP && tick);
    assign cnt_clr = (nxt != st) || holds_count_clear(st);

    // R7
    ocp_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (go && ocp_trip && (st == ST_SOFT || st == ST_RUN)) |=> st == ST_LATCH);

    // R7
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (go && st == ST_LATCH) |=> st == ST_LATCH);

    // R4
    drop_off_chk: assert property (@(posedge clk) disable iff (rst)
        !go |=> st == ST_OFF);

    // R6
    uv_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SOFT && go && fb_uv && !ocp_trip && !(ramp_step && cnt_last))
        |=> st == ST_SOFT);

    // R5
    hiccup_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && go && fb_uv && !ocp_trip) |=> st == ST_HICCUP);
endmodule

// File: rtl/bseq_out.sv
`timescale 1ns/1ps
module bseq_out
    import buck_seq_pkg::*;
#(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  seq_state_e   st,
    input  logic [W-1:0] cnt,
    input  logic         comp_sd,
    input  logic         fb_pg_hi,
    output logic [W-1:0] ss_code,
    output logic         drv_en,
    output logic         pg_release
);
    always_comb begin
        case (st)
            ST_SOFT: ss_code = cnt;
            ST_RUN:  ss_code = '1;
            default: ss_code = '0;
        endcase
    end

    assign drv_en     = (st == ST_SOFT || st == ST_RUN) && !comp_sd;
    assign pg_release = (st == ST_RUN) && fb_pg_hi && !comp_sd;

    // R8
    pg_drv_chk: assert property (@(posedge clk) disable iff (rst)
        pg_release |-> drv_en);

    // R3
    ramp_mono_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SOFT && $past(st) == ST_SOFT) |-> ss_code >= $past(ss_code));

    // R9
    sd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SOFT && comp_sd) |=> (st != ST_SOFT || $stable(ss_code)));
endmodule

// File: rtl/buck_seq.sv
`timescale 1ns/1ps
module buck_seq
    import buck_seq_pkg::*;
#(
    parameter int CODE_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por_ok,
    input  logic              en_hi,
    input  logic              fb_uv,
    input  logic              fb_pg_hi,
    input  logic              ocp_trip,
    input  logic              comp_sd,
    input  logic              cyc_tick,
    output logic [CODE_W-1:0] ss_code,
    output logic              drv_en,
    output logic              pg_release
);
    seq_state_e        st;
    logic              cnt_clr, cnt_inc, cnt_last, go;
    logic [CODE_W-1:0] cnt;

    assign go = por_ok && en_hi;

    bseq_ctrl u_ctrl (
        .clk(clk), .rst(rst), .go(go), .fb_uv(fb_uv), .ocp_trip(ocp_trip),
        .comp_sd(comp_sd), .tick(cyc_tick), .cnt_last(cnt_last),
        .st(st), .cnt_clr(cnt_clr), .cnt_inc(cnt_inc)
    );

    bseq_count #(.W(CODE_W)) u_count (
        .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc),
        .cnt(cnt), .last(cnt_last)
    );

    bseq_out #(.W(CODE_W)) u_out (
        .clk(clk), .rst(rst), .st(st), .cnt(cnt), .comp_sd(comp_sd),
        .fb_pg_hi(fb_pg_hi), .ss_code(ss_code), .drv_en(drv_en),
        .pg_release(pg_release)
    );

    // R2
    start_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !go |=> (!drv_en && ss_code == '0));
endmodule

// File: tb/buck_seq_tb_top.sv
`timescale 1ns/1ps
module buck_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        por_ok = 0, en_hi = 0, fb_uv = 0, fb_pg_hi = 0;
    logic        ocp_trip = 0, comp_sd = 0, cyc_tick = 0;
    logic [10:0] ss_code;
    logic        drv_en, pg_release;
    int          n_chk = 0, n_err = 0;

    always #5 clk = ~clk;

    buck_seq dut_i (
        .clk(clk), .rst(rst), .por_ok(por_ok), .en_hi(en_hi), .fb_uv(fb_uv),
        .fb_pg_hi(fb_pg_hi), .ocp_trip(ocp_trip), .comp_sd(comp_sd),
        .cyc_tick(cyc_tick), .ss_code(ss_code), .drv_en(drv_en),
        .pg_release(pg_release)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        cyc_tick = 1'b1;
        repeat (n) @(negedge clk);
        cyc_tick = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 drv_en", drv_en, 0);
        chk("R1 ss_code", ss_code, 0);
        chk("R1 pg", pg_release, 0);
    endtask

    task automatic t_gate;
        fb_pg_hi = 1; por_ok = 1; en_hi = 0;
        ticks(5);
        chk("R2 por only drv", drv_en, 0);
        chk("R2 por only code", ss_code, 0);
        por_ok = 0; en_hi = 1;
        ticks(5);
        chk("R2 en only drv", drv_en, 0);
        chk("R2 en only code", ss_code, 0);
        en_hi = 0;
        cyc(1);
    endtask

    task automatic t_softstart;
        por_ok = 1; en_hi = 1;
        cyc(1);
        chk("R3 start drv", drv_en, 1);
        chk("R3 start code", ss_code, 0);
        ticks(100);
        chk("R3 code after 100", ss_code, 100);
        fb_uv = 1;
        ticks(50);
        chk("R6 code with uv", ss_code, 150);
        chk("R6 drv with uv", drv_en, 1);
        fb_uv = 0;
        cyc(4);
        chk("R3 hold without tick", ss_code, 150);
        ticks(1897);
        chk("R3 code at 2047", ss_code, 2047);
        chk("R3 pg before end", pg_release, 0);
        ticks(1);
        chk("R3 pg at run", pg_release, 1);
        chk("R3 run code", ss_code, 2047);
        chk("R3 run drv", drv_en, 1);
    endtask

    task automatic t_run_pg;
        fb_pg_hi = 0; cyc(1);
        chk("R8 pg follows low", pg_release, 0);
        fb_pg_hi = 1; cyc(1);
        chk("R8 pg follows high", pg_release, 1);
        comp_sd = 1; cyc(1);
        chk("R9 sd drv", drv_en, 0);
        chk("R9 sd pg", pg_release, 0);
        comp_sd = 0; cyc(1);
        chk("R9 sd release drv", drv_en, 1);
        chk("R8 pg after sd", pg_release, 1);
    endtask

    task automatic t_hiccup;
        fb_uv = 1; cyc(1); fb_uv = 0;
        chk("R5 hiccup drv", drv_en, 0);
        chk("R5 hiccup code", ss_code, 0);
        chk("R5 hiccup pg", pg_release, 0);
        ticks(2047);
        chk("R5 wait 2047 drv", drv_en, 0);
        ticks(1);
        chk("R5 restart drv", drv_en, 1);
        chk("R5 restart code", ss_code, 0);
        ticks(2048);
        chk("R5 back to run", pg_release, 1);
    endtask

    task automatic t_drop;
        en_hi = 0; cyc(1);
        chk("R4 drop drv", drv_en, 0);
        chk("R4 drop code", ss_code, 0);
        chk("R4 drop pg", pg_release, 0);
        en_hi = 1; cyc(1);
        chk("R4 restart drv", drv_en, 1);
        ticks(10);
        chk("R9 code before sd", ss_code, 10);
        comp_sd = 1; cyc(1);
        chk("R9 sd in ramp drv", drv_en, 0);
        ticks(5);
        chk("R9 sd freezes code", ss_code, 10);
        comp_sd = 0;
        ticks(3);
        chk("R9 resume code", ss_code, 13);
    endtask

    task automatic t_ocp;
        ocp_trip = 1; cyc(1); ocp_trip = 0;
        chk("R7 latch drv", drv_en, 0);
        chk("R7 latch code", ss_code, 0);
        fb_uv = 1;
        ticks(1500);
        fb_uv = 0; comp_sd = 1;
        ticks(1500);
        comp_sd = 0; cyc(1);
        chk("R7 latch holds drv", drv_en, 0);
        chk("R7 latch holds pg", pg_release, 0);
        por_ok = 0; cyc(1); por_ok = 1; cyc(1);
        chk("R7 fresh start drv", drv_en, 1);
        chk("R7 fresh start code", ss_code, 0);
        ticks(2048);
        chk("R7 run again", pg_release, 1);
        ocp_trip = 1; cyc(1); ocp_trip = 0;
        chk("R7 latch from run drv", drv_en, 0);
        chk("R7 latch from run pg", pg_release, 0);
        ticks(10);
        chk("R7 still latched", drv_en, 0);
        en_hi = 0; cyc(1); en_hi = 1; cyc(1);
        chk("R7 clear by enable", drv_en, 1);
    endtask

    initial begin
        cyc(3);
        rst = 0;
        cyc(1);
        t_reset();
        t_gate();
        t_softstart();
        t_run_pg();
        t_hiccup();
        t_drop();
        t_ocp();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule